// File: doc/BRIEF.md
# Flash Page Program Buffer

This block is the device-side write path of a serial NOR flash model. A host frames each command with an active-low chip select. Serial data arrives one bit per strobe, most significant bit first. A program command carries a 24-bit address and then a run of data bytes. The block collects those bytes in a one-page staging buffer. The first byte goes to the in-page offset taken from the low address bits, and each following byte goes to the next offset, wrapping inside the page. When chip select is released, the captured bytes are copied into a small behavioural memory array. Offsets that received no byte keep their earlier contents.

A write-enable flag must be set before a program is accepted. A dedicated one-byte command sets it. Every program frame clears it at the frame's end, whether the program was accepted or rejected. The memory array can be read back through a simple registered read port. The `busy` flag is high while a commit is copying the page.

Top module: `flash_pgm_path`

## Requirements
- R1: After reset, `wel` and `busy` are both 0.
- R2: A frame whose first byte is 06h sets `wel` to 1 once chip select goes high.
- R3: A frame with first byte 02h, followed by address bytes A[23:16], A[15:8], A[7:0] (each MSB first), stores the following data bytes at successive offsets. The first byte goes to offset A[7:0] of page (A[23:8] mod NUM_PAGES), at array address page*256+offset. Offsets that receive no byte keep their value.
- R4: After offset 255 the next data byte goes to offset 0 of the same page. When more than 256 bytes are sent, later bytes overwrite earlier ones.
- R5: A program frame that starts while `wel` is 0 leaves the memory array unchanged.
- R6: `wel` is 0 after any program frame ends, whether or not the program was accepted.
- R7: A program frame that ends with no complete data byte leaves memory unchanged and still clears `wel`.
- R8: Bits of an incomplete trailing byte at chip-select release are discarded. Only complete bytes are stored.
- R9: An accepted program raises `busy` for exactly 257 cycles. A frame whose opcode byte completes while `busy` is high has no effect.
- R10: `rd_data` shows the array byte at `rd_addr` one clock after the address is applied. Locations that were never programmed read FFh.
- R11: A frame whose first byte is neither 06h nor 02h changes neither `wel` nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select that frames a command |
| sck_en | input | 1 | One-cycle strobe: sample `si` as the next serial bit |
| si | input | 1 | Serial data input, MSB first |
| rd_addr | input | 10 | Array read address (page*256+offset) |
| rd_data | output | 8 | Registered array read data |
| wel | output | 1 | Write-enable flag |
| busy | output | 1 | Commit in progress |

## Verification
The assertions check the following on every cycle:
- the reset values;
- that a commit starts only when the write-enable flag was set just before, and that the flag is clear once the commit begins;
- that `busy` lasts exactly one page sweep plus one cycle;
- that the flag never rises during a commit.

The array contents can only be shown through the bench's scenarios. These compare the whole array against an arithmetic model after each scenario: unarmed programs, offset wrap past 256 bytes, empty and partial-byte frames, folding of high address bits, and frames sent during a commit.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
  localparam logic [7:0] OPC_ARM  = 8'h06;
  localparam logic [7:0] OPC_PROG = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_ARM,
    ST_SKIP
  } fpp_state_e;
endpackage

// File: rtl/fpp_shifter.sv
module fpp_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck_en,
  input  logic       si,
  output logic       byte_vld,
  output logic [7:0] byte_q,
  output logic       frame_end
);
  logic [2:0] bit_cnt;
  logic [6:0] sh;
  logic       cs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      sh        <= '0;
      byte_vld  <= 1'b0;
      byte_q    <= '0;
      frame_end <= 1'b0;
      cs_prev   <= 1'b1;
    end else begin
      byte_vld  <= 1'b0;
      frame_end <= cs_n & ~cs_prev;
      cs_prev   <= cs_n;
      if (cs_n) begin
        bit_cnt <= '0;
      end else if (sck_en) begin
        sh      <= {sh[5:0], si};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_q   <= {sh, si};
        end
      end
    end
  end
endmodule

// File: rtl/fpp_cmd_fsm.sv
module fpp_cmd_fsm
  import fpp_pkg::*;
#(
  parameter int OFF_W     = 8,
  parameter int PG_W      = 2,
  parameter int NUM_PAGES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_vld,
  input  logic [7:0]       byte_q,
  input  logic             frame_end,
  input  logic             busy,
  output logic             wel,
  output logic             buf_we,
  output logic [OFF_W-1:0] buf_off,
  output logic [7:0]       buf_wdata,
  output logic             commit_go,
  output logic [PG_W-1:0]  commit_page
);
  fpp_state_e       state;
  logic             armed;
  logic             got_any;
  logic [1:0]       acnt;
  logic [15:0]      addr_hi;
  logic [OFF_W-1:0] off_q;
  logic [PG_W-1:0]  page_q;
  logic [23:0]      full_addr;

  assign full_addr = {addr_hi, byte_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_OPC;
      wel         <= 1'b0;
      armed       <= 1'b0;
      got_any     <= 1'b0;
      acnt        <= '0;
      addr_hi     <= '0;
      off_q       <= '0;
      page_q      <= '0;
      buf_we      <= 1'b0;
      buf_off     <= '0;
      buf_wdata   <= '0;
      commit_go   <= 1'b0;
      commit_page <= '0;
    end else begin
      buf_we    <= 1'b0;
      commit_go <= 1'b0;
      if (frame_end) begin
        if (state == ST_ARM) wel <= 1'b1;
        if (state == ST_ADDR || state == ST_DATA) wel <= 1'b0;
        if (state == ST_DATA && armed && got_any) begin
          commit_go   <= 1'b1;
          commit_page <= page_q;
        end
        state <= ST_OPC;
      end else if (byte_vld) begin
        case (state)
          ST_OPC: begin
            if (busy) begin
              state <= ST_SKIP;
            end else if (byte_q == OPC_ARM) begin
              state <= ST_ARM;
            end else if (byte_q == OPC_PROG) begin
              armed   <= wel;
              got_any <= 1'b0;
              acnt    <= '0;
              state   <= ST_ADDR;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_ADDR: begin
            addr_hi <= {addr_hi[7:0], byte_q};
            acnt    <= acnt + 2'd1;
            if (acnt == 2'd2) begin
              off_q  <= full_addr[OFF_W-1:0];
              page_q <= PG_W'(full_addr[23:OFF_W] % NUM_PAGES);
              state  <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (armed) begin
              buf_we    <= 1'b1;
              buf_off   <= off_q;
              buf_wdata <= byte_q;
              off_q     <= off_q + 1'b1;
              got_any   <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fpp_page_buf.sv
module fpp_page_buf #(
  parameter int PAGE_BYTES = 256,
  parameter int OFF_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_data,
  input  logic             rd_en,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_data,
  output logic             rd_valid
);
  logic [7:0]            ram [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) ram[wr_off] <= wr_data;
    if (rd_en) rd_data <= ram[rd_off];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (we) vld[wr_off] <= 1'b1;
      if (rd_en) begin
        rd_valid    <= vld[rd_off];
        vld[rd_off] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpp_commit.sv
module fpp_commit #(
  parameter int PAGE_BYTES = 256,
  parameter int OFF_W      = 8,
  parameter int PG_W       = 2,
  localparam int MEM_W     = OFF_W + PG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [PG_W-1:0]  page,
  output logic             buf_rd_en,
  output logic [OFF_W-1:0] buf_rd_off,
  input  logic [7:0]       buf_rd_data,
  input  logic             buf_rd_valid,
  output logic             mem_we,
  output logic [MEM_W-1:0] mem_waddr,
  output logic [7:0]       mem_wdata,
  output logic             busy
);
  logic             running;
  logic             stage_v;
  logic [OFF_W-1:0] ridx;
  logic [OFF_W-1:0] sidx;
  logic [PG_W-1:0]  pg;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      stage_v <= 1'b0;
      ridx    <= '0;
      sidx    <= '0;
      pg      <= '0;
    end else begin
      stage_v <= running;
      sidx    <= ridx;
      if (go) begin
        running <= 1'b1;
        ridx    <= '0;
        pg      <= page;
      end else if (running) begin
        ridx <= ridx + 1'b1;
        if (ridx == OFF_W'(PAGE_BYTES - 1)) running <= 1'b0;
      end
    end
  end

  assign buf_rd_en  = running;
  assign buf_rd_off = ridx;
  assign mem_we     = stage_v & buf_rd_valid;
  assign mem_waddr  = {pg, sidx};
  assign mem_wdata  = buf_rd_data;
  assign busy       = running | stage_v;
endmodule

// File: rtl/fpp_array.sv
module fpp_array #(
  parameter int DEPTH = 1024,
  parameter int MEM_W = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [MEM_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [MEM_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_pgm_path.sv
module flash_pgm_path #(
  parameter int  PAGE_BYTES = 256,
  parameter int  NUM_PAGES  = 4,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int PG_W       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int MEM_W      = OFF_W + PG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sck_en,
  input  logic             si,
  input  logic [MEM_W-1:0] rd_addr,
  output logic [7:0]       rd_data,
  output logic             wel,
  output logic             busy
);
  localparam int DEPTH = NUM_PAGES * PAGE_BYTES;

  logic             byte_vld;
  logic [7:0]       byte_q;
  logic             frame_end;
  logic             buf_we;
  logic [OFF_W-1:0] buf_off;
  logic [7:0]       buf_wdata;
  logic             commit_go;
  logic [PG_W-1:0]  commit_page;
  logic             buf_rd_en;
  logic [OFF_W-1:0] buf_rd_off;
  logic [7:0]       buf_rd_data;
  logic             buf_rd_valid;
  logic             mem_we;
  logic [MEM_W-1:0] mem_waddr;
  logic [7:0]       mem_wdata;

  fpp_shifter u_shift (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck_en(sck_en), .si(si),
    .byte_vld(byte_vld), .byte_q(byte_q), .frame_end(frame_end)
  );

  fpp_cmd_fsm #(.OFF_W(OFF_W), .PG_W(PG_W), .NUM_PAGES(NUM_PAGES)) u_fsm (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_q(byte_q),
    .frame_end(frame_end), .busy(busy), .wel(wel),
    .buf_we(buf_we), .buf_off(buf_off), .buf_wdata(buf_wdata),
    .commit_go(commit_go), .commit_page(commit_page)
  );

  fpp_page_buf #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst(rst), .we(buf_we), .wr_off(buf_off), .wr_data(buf_wdata),
    .rd_en(buf_rd_en), .rd_off(buf_rd_off), .rd_data(buf_rd_data),
    .rd_valid(buf_rd_valid)
  );

  fpp_commit #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .PG_W(PG_W)) u_commit (
    .clk(clk), .rst(rst), .go(commit_go), .page(commit_page),
    .buf_rd_en(buf_rd_en), .buf_rd_off(buf_rd_off),
    .buf_rd_data(buf_rd_data), .buf_rd_valid(buf_rd_valid),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .busy(busy)
  );

  fpp_array #(.DEPTH(DEPTH), .MEM_W(MEM_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/fpp_checker.sv
module fpp_checker #(
  parameter int PAGE_BYTES = 256
) (
  input logic clk,
  input logic rst,
  input logic wel,
  input logic busy
);
  int run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else run_len <= 0;
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!wel && !busy));

  p_commit_armed_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel, 2));

  p_wel_dropped_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !wel);

  p_busy_bound_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_len < PAGE_BYTES + 1);

  p_busy_exact_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_len == PAGE_BYTES + 1);

  p_no_arm_in_commit_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> !busy);
endmodule

bind flash_pgm_path fpp_checker #(.PAGE_BYTES(PAGE_BYTES)) u_fpp_chk (
  .clk(clk), .rst(rst), .wel(wel), .busy(busy)
);

// File: tb/flash_pgm_path_test.sv
module flash_pgm_path_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPG  = 4;
  localparam int PGB  = 256;
  localparam int MEMN = NPG * PGB;

  logic       clk = 1'b0;
  logic       rst;
  logic       cs_n;
  logic       sck_en;
  logic       si;
  logic [9:0] rd_addr;
  logic [7:0] rd_data;
  logic       wel;
  logic       busy;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;
  logic [7:0] model [MEMN];

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_pgm_path uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck_en(sck_en), .si(si),
    .rd_addr(rd_addr), .rd_data(rd_data), .wel(wel), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 31 + i * 7 + 3) & 255);
  endfunction

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk);
      si = b[i];
      sck_en = 1'b1;
      @(negedge clk);
      sck_en = 1'b0;
    end
  endtask

  task automatic open_frame;
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic close_frame;
    @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle;
    int g = 0;
    repeat (4) @(negedge clk);
    while (busy && g < 1000) begin
      @(negedge clk);
      g++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic arm;
    open_frame();
    send_bits(8'h06, 8);
    close_frame();
  endtask

  // program frame; model updated when the program is expected to take effect
  task automatic prog(input logic [23:0] addr, input int n, input int seed,
                      input bit expect_ok);
    int base = ((int'(addr) >> 8) % NPG) * PGB;
    open_frame();
    send_bits(8'h02, 8);
    send_bits(addr[23:16], 8);
    send_bits(addr[15:8], 8);
    send_bits(addr[7:0], 8);
    for (int i = 0; i < n; i++) begin
      send_bits(pat(seed, i), 8);
      if (expect_ok) model[base + ((int'(addr[7:0]) + i) & 255)] = pat(seed, i);
    end
    close_frame();
  endtask

  task automatic mem_check(input string req);
    int bad = 0;
    int first_a = 0;
    int first_act = 0;
    int first_exp = 0;
    for (int a = 0; a < MEMN; a++) begin
      @(negedge clk);
      rd_addr = 10'(a);
      @(negedge clk);
      if (rd_data !== model[a]) begin
        if (bad == 0) begin
          first_a = a;
          first_act = int'(rd_data);
          first_exp = int'(model[a]);
        end
        bad++;
      end
    end
    check(bad == 0, req, $sformatf("array sweep (first bad addr %0h)", first_a),
          first_act, first_exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    int g;
    for (int a = 0; a < MEMN; a++) model[a] = 8'hFF;
    rst = 1'b1; cs_n = 1'b1; sck_en = 1'b0; si = 1'b0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R10 erased contents and read latency
    check(wel == 1'b0, "R1", "wel after reset", int'(wel), 0);
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    mem_check("R10");

    // R5 unarmed program
    prog(24'h000110, 5, 1, 1'b0);
    wait_idle();
    check(wel == 1'b0, "R5", "wel after unarmed program", int'(wel), 0);
    mem_check("R5");

    // R2 arm, R11 foreign opcode
    arm();
    check(wel == 1'b1, "R2", "wel after arm frame", int'(wel), 1);
    open_frame();
    send_bits(8'h9F, 8);
    send_bits(8'h12, 8);
    send_bits(8'h34, 8);
    close_frame();
    check(wel == 1'b1, "R11", "wel after foreign opcode", int'(wel), 1);

    // R3 basic program, R9 busy length, R6 clear
    prog(24'h000005, 10, 2, 1'b1);
    g = 0;
    while (!busy && g < 20) begin @(negedge clk); g++; end
    cnt = 0;
    while (busy && cnt < 2000) begin @(negedge clk); cnt++; end
    check(cnt == 257, "R9", "busy cycles", cnt, 257);
    check(wel == 1'b0, "R6", "wel after accepted program", int'(wel), 0);
    repeat (2) @(negedge clk);
    mem_check("R3");
    mem_check("R11");

    // R4 wrap with overwrite
    arm();
    prog(24'h0003F0, 300, 3, 1'b1);
    wait_idle();
    check(wel == 1'b0, "R6", "wel after wrapped program", int'(wel), 0);
    mem_check("R4");

    // R7 no data bytes
    arm();
    prog(24'h000240, 0, 4, 1'b1);
    wait_idle();
    check(wel == 1'b0, "R7", "wel after empty program", int'(wel), 0);
    mem_check("R7");

    // R8 partial trailing byte
    arm();
    open_frame();
    send_bits(8'h02, 8);
    send_bits(8'h00, 8);
    send_bits(8'h01, 8);
    send_bits(8'h80, 8);
    send_bits(8'h5A, 8);
    send_bits(8'hC3, 8);
    send_bits(8'hAA, 5);
    close_frame();
    model[256 + 8'h80] = 8'h5A;
    model[256 + 8'h81] = 8'hC3;
    wait_idle();
    mem_check("R8");

    // R3 high address bits fold onto the page count
    arm();
    prog(24'hAB0520, 3, 5, 1'b1);
    wait_idle();
    mem_check("R3");

    // R9 frame during commit is ignored
    arm();
    prog(24'h000300, 1, 6, 1'b1);
    check(busy == 1'b1, "R9", "busy right after program", int'(busy), 1);
    arm();
    wait_idle();
    check(wel == 1'b0, "R9", "wel after arm sent during commit", int'(wel), 0);
    mem_check("R9");

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule